// File: doc/BRIEF.md
# Write-Only Two-Wire Clock Configuration Slave

This block is the configuration port of a board clock generator. A host writes to it over a two-wire serial bus (I2C-style, SCL and SDA). The block oversamples both wires with a fast system clock and finds start, stop and data edges. It checks the 7-bit device address and the direction bit, and acknowledges an accepted address and every data byte after it. It then stores the data bytes in order into a small set of configuration registers, always beginning at register 0.

The register contents drive the generator's control outputs. These are a global three-state control, a test-mode select, and one enable per output clock. The clock groups are the CPU, AGP, PCI (four gated and one free-running), USB, memory (SDRAM) and reference clocks. The block never sends data back to the host, never stretches the clock and does not take part in arbitration. The acknowledge is an open-drain pull-down: the block raises an output enable, and the pad pulls SDA low while that enable is high.

Top module: `clkcfg_serial_slave`

## Requirements
- R1: After reset, `sda_pull` is 0, `tristate_all` and `test_mode` are 0, and every clock enable output is 1.
- R2: When the address byte received after a start is 1101001 followed by a write bit of 0, `sda_pull` is 1 while SCL is high during the ninth clock of that byte.
- R3: An address byte with another address, or with the direction bit set to 1, is not acknowledged. The block then neither acknowledges nor stores any byte until the next start condition.
- R4: Data bytes are taken MSB first. The first byte after an accepted address goes into register 0 and each later byte goes into the next register. Each data byte is acknowledged during its ninth clock.
- R5: In register 0, bit 1 drives `tristate_all` and bit 0 drives `test_mode`. Bits 7 to 2 have no effect on any output.
- R6: In register 1, bits 3:0 drive `cpu_en[3:0]` and bits 5:4 drive `agp_en[1:0]`.
- R7: In register 2, bits 3:0 drive `pci_en[3:0]`, bit 4 drives `pci_free_en` and bit 5 drives `usb_en`.
- R8: Register 3 drives `sdram_en[7:0]`, bit for bit. Bits 3:0 of register 4 drive `sdram_en[11:8]`, and bits 7:4 of register 4 have no effect.
- R9: Bit 0 of register 5 drives `ref_en`. Bits 7 to 1 of register 5 have no effect on any output.
- R10: Data bytes after the sixth one in a transfer are acknowledged and leave every output unchanged.
- R11: A stop condition and a repeated start both return the register pointer to 0, so the next accepted transfer writes register 0 first.
- R12: `sda_pull` is 0 after a stop condition and outside the ninth clock of an acknowledged byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock wire, asynchronous |
| sda_in | input | 1 | Serial data wire, asynchronous |
| sda_pull | output | 1 | 1 = pull SDA low (acknowledge) |
| tristate_all | output | 1 | 1 = all clock outputs in three-state |
| test_mode | output | 1 | 1 = test mode selected |
| cpu_en | output | 4 | CPU clock enables, 1 = active |
| agp_en | output | 2 | AGP clock enables, 1 = active |
| pci_en | output | 4 | Gated PCI clock enables, 1 = active |
| pci_free_en | output | 1 | Free-running PCI clock enable |
| usb_en | output | 1 | USB clock enable |
| sdram_en | output | 12 | Memory clock enables, 1 = active |
| ref_en | output | 1 | Reference clock enable |

## Verification
The assertions check on every cycle that the acknowledge enable only rises while SCL is low and is cleared by a stop. They also check that it is never raised in the skip state, that the pointer never runs past the register count, that a write strobe lasts one cycle, and that the registers hold when no write strobe is present. The bench has to show the rest: that the address compare is correct, that bits end up in the right register and field in MSB-first order, that overflow bytes are dropped, and that a repeated start rewinds the pointer. It shows these by sending randomized and directed transfers and comparing the acknowledges and all output fields with a model of the register image.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 6;
    localparam logic [6:0] DEFAULT_ADDR = 7'b1101001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_ACK,
        ST_SKIP
    } rx_state_e;
endpackage

// File: rtl/clkcfg_bus_sync.sv
module clkcfg_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_o,
    output logic sda_o,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl;
        logic [STAGES-1:0] sda;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.scl   = {sync_q.scl[STAGES-2:0], scl_in};
        sync_d.sda   = {sync_q.sda[STAGES-2:0], sda_in};
        sync_d.scl_p = sync_q.scl[STAGES-1];
        sync_d.sda_p = sync_q.sda[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign scl_o   = sync_q.scl[STAGES-1];
    assign sda_o   = sync_q.sda[STAGES-1];
    assign start_o = scl_o & sync_q.scl_p & sync_q.sda_p & ~sda_o;
    assign stop_o  = scl_o & sync_q.scl_p & ~sync_q.sda_p & sda_o;
    assign rise_o  = scl_o & ~sync_q.scl_p;
    assign fall_o  = ~scl_o & sync_q.scl_p;
endmodule

// File: rtl/clkcfg_rx_fsm.sv
module clkcfg_rx_fsm
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = DEFAULT_ADDR,
    parameter int         NREGS    = NUM_REGS,
    parameter int         PTR_W    = $clog2(NREGS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    input  logic              start,
    input  logic              stop,
    input  logic              rise,
    input  logic              fall,
    output logic              ack_oe,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data
);
    localparam logic [BYTE_W-1:0] ADDR_WR = {DEV_ADDR, 1'b0};
    localparam logic [PTR_W-1:0]  PTR_END = PTR_W'(NREGS);

    typedef struct packed {
        rx_state_e         st;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic [PTR_W-1:0]  ptr;
        logic              oe;
        logic              wr;
        logic [PTR_W-1:0]  widx;
        logic [BYTE_W-1:0] wdat;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d    = fsm_q;
        fsm_d.wr = 1'b0;
        if (start) begin
            fsm_d.st  = ST_ADDR;
            fsm_d.cnt = '0;
            fsm_d.ptr = '0;
            fsm_d.oe  = 1'b0;
        end else if (stop) begin
            fsm_d.st  = ST_IDLE;
            fsm_d.cnt = '0;
            fsm_d.ptr = '0;
            fsm_d.oe  = 1'b0;
        end else begin
            case (fsm_q.st)
                ST_ADDR, ST_DATA: begin
                    if (rise && fsm_q.cnt < 4'd8) begin
                        fsm_d.sh  = {fsm_q.sh[BYTE_W-2:0], sda};
                        fsm_d.cnt = fsm_q.cnt + 4'd1;
                    end
                    if (fall && fsm_q.cnt == 4'd8) begin
                        fsm_d.cnt = '0;
                        if (fsm_q.st == ST_ADDR) begin
                            if (fsm_q.sh == ADDR_WR) begin
                                fsm_d.st = ST_ACK;
                                fsm_d.oe = 1'b1;
                            end else begin
                                fsm_d.st = ST_SKIP;
                            end
                        end else begin
                            fsm_d.st = ST_ACK;
                            fsm_d.oe = 1'b1;
                            if (fsm_q.ptr < PTR_END) begin
                                fsm_d.wr   = 1'b1;
                                fsm_d.widx = fsm_q.ptr;
                                fsm_d.wdat = fsm_q.sh;
                                fsm_d.ptr  = fsm_q.ptr + 1'b1;
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (fall) begin
                        fsm_d.st = ST_DATA;
                        fsm_d.oe = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q    <= '0;
            fsm_q.st <= ST_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign ack_oe  = fsm_q.oe;
    assign wr_en   = fsm_q.wr;
    assign wr_idx  = fsm_q.widx;
    assign wr_data = fsm_q.wdat;

    // R2: the acknowledge pull-down only starts while SCL is low
    a_r2_ack_starts_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsm_q.oe) |-> !scl);
    // R12: a stop releases the line on the next cycle
    a_r12_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !fsm_q.oe);
    // R3: nothing is acknowledged while the bus is being ignored
    a_r3_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_SKIP) |-> !fsm_q.oe);
    // R10: the pointer never moves past the last register
    a_r10_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.ptr <= PTR_END);
    // R4: each byte produces a single-cycle write strobe
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.wr |=> !fsm_q.wr);
endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile
    import clkcfg_pkg::*;
#(
    parameter int NREGS = NUM_REGS,
    parameter int PTR_W = $clog2(NREGS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [PTR_W-1:0]        wr_idx,
    input  logic [BYTE_W-1:0]       wr_data,
    output logic [NREGS*BYTE_W-1:0] regs_o
);
    logic [NREGS*BYTE_W-1:0] regs_d, regs_q;

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        localparam logic [BYTE_W-1:0] RST_VAL = (i == 0) ? '0 : '1;
        logic [BYTE_W-1:0] byte_d;

        always_comb begin
            byte_d = regs_q[i*BYTE_W +: BYTE_W];
            if (wr_en && wr_idx == PTR_W'(i)) byte_d = wr_data;
        end
        assign regs_d[i*BYTE_W +: BYTE_W] = byte_d;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[i*BYTE_W +: BYTE_W] <= RST_VAL;
            else        regs_q[i*BYTE_W +: BYTE_W] <= regs_d[i*BYTE_W +: BYTE_W];
        end
    end

    assign regs_o = regs_q;

    // R4: registers change only when a write strobe is present
    a_r4_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));
endmodule

// File: rtl/clkcfg_serial_slave.sv
module clkcfg_serial_slave
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = DEFAULT_ADDR,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        sda_pull,
    output logic        tristate_all,
    output logic        test_mode,
    output logic [3:0]  cpu_en,
    output logic [1:0]  agp_en,
    output logic [3:0]  pci_en,
    output logic        pci_free_en,
    output logic        usb_en,
    output logic [11:0] sdram_en,
    output logic        ref_en
);
    localparam int PTR_W = $clog2(NUM_REGS + 1);

    logic scl_s, sda_s, start_s, stop_s, rise_s, fall_s;
    logic wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic [NUM_REGS*BYTE_W-1:0] regs;

    clkcfg_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_o(scl_s), .sda_o(sda_s), .start_o(start_s), .stop_o(stop_s),
        .rise_o(rise_s), .fall_o(fall_s)
    );

    clkcfg_rx_fsm #(.DEV_ADDR(DEV_ADDR), .NREGS(NUM_REGS), .PTR_W(PTR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
        .start(start_s), .stop(stop_s), .rise(rise_s), .fall(fall_s),
        .ack_oe(sda_pull), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    clkcfg_regfile #(.NREGS(NUM_REGS), .PTR_W(PTR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .regs_o(regs)
    );

    logic [BYTE_W-1:0] r_ctl, r_cpu, r_pci, r_mlo, r_mhi, r_per;
    assign r_ctl = regs[0*BYTE_W +: BYTE_W];
    assign r_cpu = regs[1*BYTE_W +: BYTE_W];
    assign r_pci = regs[2*BYTE_W +: BYTE_W];
    assign r_mlo = regs[3*BYTE_W +: BYTE_W];
    assign r_mhi = regs[4*BYTE_W +: BYTE_W];
    assign r_per = regs[5*BYTE_W +: BYTE_W];

    assign tristate_all = r_ctl[1];
    assign test_mode    = r_ctl[0];
    assign cpu_en       = r_cpu[3:0];
    assign agp_en       = r_cpu[5:4];
    assign pci_en       = r_pci[3:0];
    assign pci_free_en  = r_pci[4];
    assign usb_en       = r_pci[5];
    assign sdram_en     = {r_mhi[3:0], r_mlo};
    assign ref_en       = r_per[0];
endmodule

// File: tb/clkcfg_serial_slave_tb.sv
module clkcfg_serial_slave_tb;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_line;
    logic sda_pull, tristate_all, test_mode, pci_free_en, usb_en, ref_en;
    logic [3:0] cpu_en, pci_en;
    logic [1:0] agp_en;
    logic [11:0] sdram_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [7:0] model [0:5];
    logic [7:0] buff [0:7];

    always #10 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    clkcfg_serial_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .sda_pull(sda_pull), .tristate_all(tristate_all), .test_mode(test_mode),
        .cpu_en(cpu_en), .agp_en(agp_en), .pci_en(pci_en),
        .pci_free_en(pci_free_en), .usb_en(usb_en), .sdram_en(sdram_en),
        .ref_en(ref_en)
    );

    function automatic logic [26:0] exp_vec();
        return {model[0][1], model[0][0], model[1][3:0], model[1][5:4],
                model[2][3:0], model[2][4], model[2][5], model[4][3:0],
                model[3], model[5][0]};
    endfunction

    function automatic logic [26:0] dut_vec();
        return {tristate_all, test_mode, cpu_en, agp_en, pci_en,
                pci_free_en, usb_en, sdram_en, ref_en};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_outputs(input string tag);
        chk(dut_vec() == exp_vec(), tag, 32'(dut_vec()), 32'(exp_vec()));
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b1; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wait_q();
            m_scl = 1'b1; wait_q();
            m_scl = 1'b0; wait_q();
        end
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        ack = sda_pull;
        m_scl = 1'b0; wait_q();
    endtask

    // full transfer: start, address byte, n data bytes from buff, stop
    task automatic xfer(input logic [7:0] abyte, input int n, input bit good,
                        input string tag);
        logic ack;
        bus_start();
        send_byte(abyte, ack);
        chk(ack == good, tag, 32'(ack), 32'(good));
        for (int k = 0; k < n; k++) begin
            send_byte(buff[k], ack);
            chk(ack == good, tag, 32'(ack), 32'(good));
            if (good && k < 6) model[k] = buff[k];
        end
        bus_stop();
        wait_q();
        chk(sda_pull == 1'b0, "R12 line released after stop", 32'(sda_pull), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic ack;
        void'($urandom(32'h5eed_0042));
        model[0] = 8'h00;
        for (int i = 1; i < 6; i++) model[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk_outputs("R1 reset outputs");
        chk(sda_pull == 1'b0, "R1 reset sda_pull", 32'(sda_pull), 0);

        // R2 R4 R5 R6 R7 R8 R9: write all six registers
        buff[0] = 8'hFE; buff[1] = 8'h9A; buff[2] = 8'h55;
        buff[3] = 8'h3C; buff[4] = 8'hA6; buff[5] = 8'h01;
        xfer(8'hD2, 6, 1'b1, "R2 R4 ack of write");
        chk(tristate_all == 1'b1 && test_mode == 1'b0, "R5 control bits",
            32'({tristate_all, test_mode}), 32'b10);
        chk(cpu_en == 4'hA && agp_en == 2'b01, "R6 cpu/agp",
            32'({cpu_en, agp_en}), 32'({4'hA, 2'b01}));
        chk(pci_en == 4'h5 && pci_free_en == 1'b1 && usb_en == 1'b0, "R7 pci/usb",
            32'({pci_en, pci_free_en, usb_en}), 32'({4'h5, 2'b10}));
        chk(sdram_en == 12'h63C, "R8 sdram", 32'(sdram_en), 32'h63C);
        chk(ref_en == 1'b1, "R9 ref", 32'(ref_en), 1);
        chk_outputs("R4 full image");

        // R9 reserved bits of register 5 and register 0 do nothing
        buff[0] = 8'hFC; buff[1] = 8'h9A; buff[2] = 8'h55;
        buff[3] = 8'h3C; buff[4] = 8'h06; buff[5] = 8'hFE;
        xfer(8'hD2, 6, 1'b1, "R4 ack");
        chk(ref_en == 1'b0, "R9 reserved ignored, ref", 32'(ref_en), 0);
        chk(tristate_all == 1'b0 && test_mode == 1'b0, "R5 reserved ignored",
            32'({tristate_all, test_mode}), 0);
        chk(sdram_en == 12'h63C, "R8 upper nibble ignored", 32'(sdram_en), 32'h63C);

        // R10 overflow bytes acked and dropped
        for (int i = 0; i < 8; i++) buff[i] = 8'(8'h11 * (i + 1));
        xfer(8'hD2, 8, 1'b1, "R10 overflow ack");
        chk_outputs("R10 overflow discarded");

        // R3 wrong address and read bit
        buff[0] = 8'h03; buff[1] = 8'h00;
        xfer(8'hD4, 2, 1'b0, "R3 wrong address nack");
        chk_outputs("R3 wrong address no write");
        xfer(8'hD3, 2, 1'b0, "R3 read bit nack");
        chk_outputs("R3 read bit no write");

        // R11 repeated start rewinds the pointer
        bus_start();
        send_byte(8'hD2, ack);
        send_byte(8'h02, ack); model[0] = 8'h02;
        send_byte(8'h0F, ack); model[1] = 8'h0F;
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b0; wait_q();
        send_byte(8'hD2, ack);
        chk(ack == 1'b1, "R11 ack after repeated start", 32'(ack), 1);
        send_byte(8'h01, ack); model[0] = 8'h01;
        bus_stop();
        wait_q();
        chk_outputs("R11 repeated start writes register 0");

        // R11 stop rewinds pointer
        buff[0] = 8'h00;
        xfer(8'hD2, 1, 1'b1, "R11 ack");
        chk_outputs("R11 stop rewinds pointer");

        // random transfers
        for (int t = 0; t < 24; t++) begin
            int n;
            bit good;
            logic [7:0] ab;
            n = 1 + int'($urandom % 8);
            good = ($urandom % 4) != 0;
            if (good) ab = 8'hD2;
            else begin
                ab = 8'($urandom);
                if (ab == 8'hD2) ab = 8'hD3;
            end
            for (int i = 0; i < 8; i++) buff[i] = 8'($urandom);
            xfer(ab, n, good, good ? "R4 random ack" : "R3 random nack");
            chk_outputs("R4 R6 R7 R8 random image");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule